// File: doc/BRIEF.md
# Register-to-DRP Configuration Bridge

This block sits between a processor register bus and the dynamic reconfiguration port of a clock-synthesis primitive. The processor writes one 32-bit command word. That word holds a start flag, a direction flag, a 7-bit port address and 16 bits of data. The write launches a single reconfiguration transaction. The processor then polls a status word until the busy flag drops, and for a read it takes the returned data from the low half of that status word.

A second register holds two control levels, a core reset release and a primitive enable. Software uses them to hold the clock primitive disabled while it rewrites the divider, lock and filter settings. The bus is minimal: a word address, a single-cycle write strobe, a read strobe, and read data that is registered so it arrives one cycle after the strobe.

Top module: `cfg_drp_bridge`

## Requirements
- R1: After reset, the level outputs, the DRP enable and write-enable are 0, and the reset/enable, control and status registers all read as 0.
- R2: The reset/enable register is at word address 0x10 (byte 0x40). Bit 0 drives `core_release` and bit 1 drives `prim_enable`, each one cycle after the write. Only bits 1:0 are stored and read back; writing 0x1 leaves the primitive disabled.
- R3: A write to the control register at word 0x1C (byte 0x70) with bit 29 set, while idle, raises `drp_en` in the cycle after the strobe for exactly one cycle. In that cycle `drp_addr` equals bits 22:16 and `drp_wdata` equals bits 15:0, and both hold until the transaction ends.
- R4: Bit 28 of the control word selects the direction: 1 for a read and 0 for a write. `drp_we` is high together with `drp_en` for a write and stays low for a read.
- R5: Status bit 16 at word 0x1D (byte 0x74) is the busy flag. It is set from the cycle `drp_en` rises and clears in the cycle after the `drp_rdy` pulse, whatever the responder's delay.
- R6: When a read transaction completes, `drp_rdata` is latched into status bits 15:0 in the cycle busy clears. A write transaction leaves those bits unchanged.
- R7: A control-register write that arrives while busy is ignored: no new `drp_en` pulse, and the control register keeps its previous value.
- R8: A control write with bit 29 clear starts no transaction but is still stored and read back.
- R9: The control register reads back only bits 29, 28, 22:16 and 15:0 of the last accepted write. All other bits and unmapped word addresses read as 0.
- R10: Bus read data appears in the cycle after the read strobe and holds until the next read strobe.
- R11: A `drp_rdy` pulse while no transaction is outstanding changes neither busy nor the status data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_release | output | 1 | Core reset release level (reset register bit 0) |
| prim_enable | output | 1 | Clock primitive enable level (reset register bit 1) |
| drp_en | output | 1 | DRP transaction enable pulse |
| drp_we | output | 1 | DRP write-enable, valid with drp_en |
| drp_addr | output | 7 | DRP register address |
| drp_wdata | output | 16 | DRP write data |
| drp_rdata | input | 16 | DRP read data, valid with drp_rdy |
| drp_rdy | input | 1 | DRP completion pulse |

## Verification
Every one of the 128 port addresses is written with a value computed from the address, then read back. The responder's delay cycles through 0 to 4 cycles, so an address or data bit stuck or swapped shows up as a mismatch, and a completion that lands while the enable is still high is exercised. A long-delay read is polled at the exact cycle of the ready pulse and the cycle after it, which separates a busy flag that clears one cycle early or late. Further patterns are a command aimed at a busy bridge, a command with the start bit clear, a stray ready pulse, and an all-ones command word; each shows whether the bridge ignores, stores or masks it.

// File: rtl/cdb_pkg.sv
// Shared constants and types for the register-to-DRP bridge.
// Assumes a 32-bit register bus; bit positions are fixed by the software view.
package cdb_pkg;
    localparam int BUS_DW    = 32;
    localparam int START_BIT = 29;
    localparam int READ_BIT  = 28;
    localparam int FIELD_LSB = 16;
    localparam int BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ISSUE = 2'd1,
        ENG_WAIT  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/cdb_drp_engine.sv
// DRP transaction engine: turns a one-cycle start request into a single
// drp_en pulse, holds address/data until drp_rdy, and captures read data.
// Assumes the responder returns exactly one drp_rdy per drp_en.
module cdb_drp_engine
    import cdb_pkg::*;
#(
    parameter int DRP_AW = 7,
    parameter int DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [DRP_AW-1:0] addr_i,
    input  logic [DRP_DW-1:0] wdata_i,
    output logic              busy_o,
    output logic [DRP_DW-1:0] rdata_o,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_wdata,
    input  logic [DRP_DW-1:0] drp_rdata,
    input  logic              drp_rdy
);
    eng_state_t state_q;
    logic       is_rd_q;

    assign busy_o = (state_q != ENG_IDLE);

    // Sequence one transaction: issue, wait for ready, capture, return idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ENG_IDLE;
            is_rd_q   <= 1'b0;
            drp_en    <= 1'b0;
            drp_we    <= 1'b0;
            drp_addr  <= '0;
            drp_wdata <= '0;
            rdata_o   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        state_q   <= ENG_ISSUE;
                        is_rd_q   <= rd_i;
                        drp_en    <= 1'b1;
                        drp_we    <= !rd_i;
                        drp_addr  <= addr_i;
                        drp_wdata <= wdata_i;
                    end
                end
                ENG_ISSUE, ENG_WAIT: begin
                    drp_en <= 1'b0;
                    drp_we <= 1'b0;
                    if (drp_rdy) begin
                        state_q <= ENG_IDLE;
                        if (is_rd_q) begin
                            rdata_o <= drp_rdata;
                        end
                    end else begin
                        state_q <= ENG_WAIT;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    AST_LAUNCH_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> drp_en); // R3
    AST_EN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        drp_en |=> !drp_en); // R3
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !drp_rdy |=> $stable(drp_addr) && $stable(drp_wdata)); // R3
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && drp_rdy |=> !busy_o); // R5
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !drp_rdy |=> !drp_en); // R7
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && drp_rdy) |=> $stable(rdata_o)); // R11
endmodule

// File: rtl/cdb_regbank.sv
// Register bank: decodes the word-addressed bus, holds the reset/enable and
// control words, builds the status word and registers the read data.
// Assumes single-cycle strobes; a control write while busy is dropped.
module cdb_regbank
    import cdb_pkg::*;
#(
    parameter int             AW        = 6,
    parameter int             DRP_AW    = 7,
    parameter int             DRP_DW    = 16,
    parameter logic [AW-1:0]  RST_WORD  = 6'h10,
    parameter logic [AW-1:0]  CTRL_WORD = 6'h1C,
    parameter logic [AW-1:0]  STAT_WORD = 6'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              core_rel_o,
    output logic              prim_en_o,
    input  logic              busy_i,
    input  logic [DRP_DW-1:0] drp_rdata_i,
    output logic              start_o,
    output logic              cmd_rd_o,
    output logic [DRP_AW-1:0] cmd_addr_o,
    output logic [DRP_DW-1:0] cmd_data_o
);
    localparam logic [BUS_DW-1:0] CTRL_MASK =
        (BUS_DW'(1) << START_BIT) | (BUS_DW'(1) << READ_BIT) |
        (((BUS_DW'(1) << DRP_AW) - BUS_DW'(1)) << FIELD_LSB) |
        ((BUS_DW'(1) << DRP_DW) - BUS_DW'(1));

    logic [1:0]        rst_q;
    logic [BUS_DW-1:0] ctrl_q;
    logic [BUS_DW-1:0] stat_word;
    logic [BUS_DW-1:0] rd_mux;
    logic              ctrl_hit;

    assign ctrl_hit   = bus_wr && (bus_addr == CTRL_WORD) && !busy_i;
    assign start_o    = ctrl_hit && bus_wdata[START_BIT];
    assign cmd_rd_o   = bus_wdata[READ_BIT];
    assign cmd_addr_o = bus_wdata[FIELD_LSB +: DRP_AW];
    assign cmd_data_o = bus_wdata[DRP_DW-1:0];
    assign core_rel_o = rst_q[0];
    assign prim_en_o  = rst_q[1];

    // Store the reset/enable and control words on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (bus_wr && (bus_addr == RST_WORD)) begin
                rst_q <= bus_wdata[1:0];
            end
            if (ctrl_hit) begin
                ctrl_q <= bus_wdata & CTRL_MASK;
            end
        end
    end

    // Assemble the status word from busy and the last read data.
    always_comb begin
        stat_word = BUS_DW'(drp_rdata_i) | (BUS_DW'(busy_i) << BUSY_BIT);
    end

    // Select the addressed register; unmapped words return zero.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == RST_WORD)  rd_mux = BUS_DW'(rst_q);
        if (bus_addr == CTRL_WORD) rd_mux = ctrl_q;
        if (bus_addr == STAT_WORD) rd_mux = stat_word;
    end

    // Register the read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(ctrl_q)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10
    AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0); // R9
endmodule

// File: rtl/cfg_drp_bridge.sv
// Top of the register-to-DRP bridge: register bank plus transaction engine.
// Assumes one bus master and one DRP responder on the same clock.
module cfg_drp_bridge
    import cdb_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DRP_AW = 7,
    parameter int DRP_DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              core_release,
    output logic              prim_enable,
    output logic              drp_en,
    output logic              drp_we,
    output logic [DRP_AW-1:0] drp_addr,
    output logic [DRP_DW-1:0] drp_wdata,
    input  logic [DRP_DW-1:0] drp_rdata,
    input  logic              drp_rdy
);
    logic              busy;
    logic              start;
    logic              cmd_rd;
    logic [DRP_AW-1:0] cmd_addr;
    logic [DRP_DW-1:0] cmd_data;
    logic [DRP_DW-1:0] last_rd;

    cdb_regbank #(
        .AW(AW), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_rel_o(core_release), .prim_en_o(prim_enable),
        .busy_i(busy), .drp_rdata_i(last_rd),
        .start_o(start), .cmd_rd_o(cmd_rd),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
    );

    cdb_drp_engine #(
        .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .rd_i(cmd_rd), .addr_i(cmd_addr), .wdata_i(cmd_data),
        .busy_o(busy), .rdata_o(last_rd),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
        .drp_wdata(drp_wdata), .drp_rdata(drp_rdata), .drp_rdy(drp_rdy)
    );
endmodule

// File: tb/cfg_drp_bridge_bench.sv
module cfg_drp_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] W_RST  = 6'h10;
    localparam logic [5:0] W_CTRL = 6'h1C;
    localparam logic [5:0] W_STAT = 6'h1D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_release, prim_enable;
    logic        drp_en, drp_we, drp_rdy;
    logic [6:0]  drp_addr;
    logic [15:0] drp_wdata, drp_rdata;

    logic        rsp_rdy = 1'b0, spur_rdy = 1'b0;
    logic [15:0] rsp_do = '0;
    logic [15:0] rmem [128];
    int          rsp_delay = 0, rcnt = 0, en_count = 0;
    logic        rpend = 1'b0, rwe = 1'b0;
    logic [6:0]  ra = '0;
    logic [15:0] rdi = '0;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;

    assign drp_rdy   = rsp_rdy | spur_rdy;
    assign drp_rdata = rsp_rdy ? rsp_do : 16'hDEAD;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_drp_bridge u_cfg_drp_bridge (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_release(core_release), .prim_enable(prim_enable),
        .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
        .drp_wdata(drp_wdata), .drp_rdata(drp_rdata), .drp_rdy(drp_rdy)
    );

    // DRP responder: answers each enable after rsp_delay negedges.
    always @(negedge clk) begin
        rsp_rdy <= 1'b0;
        if (drp_en) begin
            en_count = en_count + 1;
            rpend = 1'b1; rcnt = rsp_delay;
            ra = drp_addr; rwe = drp_we; rdi = drp_wdata;
        end
        if (rpend) begin
            if (rcnt == 0) begin
                rsp_rdy <= 1'b1;
                rsp_do  <= rwe ? 16'h0000 : rmem[ra];
                if (rwe) rmem[ra] = rdi;
                rpend = 1'b0;
            end else begin
                rcnt = rcnt - 1;
            end
        end
    end

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 40503 + 4660);
    endfunction

    function automatic logic [31:0] mk(input logic rd, input int a, input logic [15:0] d);
        return {2'b00, 1'b1, rd, 5'b00000, 7'(a), d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Caller is at a negedge; returns at the following negedge.
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic poll_idle(output logic [31:0] st);
        st = 32'h0001_0000;
        for (int i = 0; i < 100; i++) begin
            bus_read(W_STAT, st);
            if (!st[16]) break;
        end
        check("R5 busy clears", 32'(st[16]), 32'd0);
    endtask

    task automatic drp_cmd(input logic [31:0] w, input int dly, output logic [31:0] st);
        rsp_delay = dly;
        bus_write(W_CTRL, w);
        check("R3 drp_en raised", 32'(drp_en), 32'd1);
        check("R4 drp_we per direction", 32'(drp_we), 32'(!w[28]));
        check("R3 drp_addr field", 32'(drp_addr), 32'(w[22:16]));
        check("R3 drp_wdata field", 32'(drp_wdata), 32'(w[15:0]));
        @(negedge clk);
        check("R3 drp_en single cycle", 32'(drp_en), 32'd0);
        poll_idle(st);
    endtask

    initial begin
        logic [31:0] v, st;
        int n0;
        for (int i = 0; i < 128; i++) rmem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10: reset state, read data arrives one cycle after strobe
        check("R1 core_release", 32'(core_release), 32'd0);
        check("R1 prim_enable", 32'(prim_enable), 32'd0);
        check("R1 drp_en", 32'(drp_en), 32'd0);
        bus_read(W_RST, v);  check("R1 reset reg", v, 32'd0);
        bus_read(W_CTRL, v); check("R1 ctrl reg", v, 32'd0);
        bus_read(W_STAT, v); check("R1 R10 status reg", v, 32'd0);

        // R2: reset/enable levels
        bus_write(W_RST, 32'h1);
        check("R2 release only", 32'({prim_enable, core_release}), 32'h1);
        bus_write(W_RST, 32'hFFFF_FFFF);
        check("R2 both levels", 32'({prim_enable, core_release}), 32'h3);
        bus_read(W_RST, v); check("R2 readback mask", v, 32'h3);
        bus_write(W_RST, 32'h2);
        check("R2 enable only", 32'({prim_enable, core_release}), 32'h2);

        // R3 R4 R5 R6: exhaustive write sweep, then read sweep
        for (int a = 0; a < 128; a++) drp_cmd(mk(1'b0, a, pat(a)), a % 5, st);
        for (int a = 0; a < 128; a++) begin
            drp_cmd(mk(1'b1, a, 16'h0), (a + 2) % 5, st);
            check("R6 read data", 32'(st[15:0]), 32'(pat(a)));
        end

        // R6: a write transaction keeps the last read data
        drp_cmd(mk(1'b0, 5, 16'h7777), 1, st);
        check("R6 write keeps data", 32'(st[15:0]), 32'(pat(127)));

        // R5: busy exact clearing cycle with a 4-cycle ready delay
        rsp_delay = 4;
        bus_write(W_CTRL, mk(1'b1, 9, 16'h0));
        repeat (4) @(negedge clk);
        bus_read(W_STAT, v); check("R5 busy at ready cycle", 32'(v[16]), 32'd1);
        bus_read(W_STAT, v); check("R5 busy cleared next cycle", 32'(v[16]), 32'd0);
        check("R6 data latched with clear", 32'(v[15:0]), 32'(pat(9)));

        // R7: control write while busy is ignored
        n0 = en_count;
        rsp_delay = 6;
        bus_write(W_CTRL, mk(1'b1, 20, 16'h0));
        bus_write(W_CTRL, mk(1'b0, 21, 16'hBEEF));
        bus_read(W_CTRL, v); check("R7 ctrl unchanged", v, mk(1'b1, 20, 16'h0));
        poll_idle(st);
        repeat (3) @(negedge clk);
        check("R7 one enable only", 32'(en_count - n0), 32'd1);
        check("R7 target untouched", 32'(rmem[21]), 32'(pat(21)));

        // R8: start bit clear stores but launches nothing
        n0 = en_count;
        bus_write(W_CTRL, 32'h1045_1234);
        repeat (4) @(negedge clk);
        check("R8 no enable", 32'(en_count - n0), 32'd0);
        bus_read(W_CTRL, v); check("R8 stored", v, 32'h1045_1234);
        bus_read(W_STAT, v); check("R8 not busy", 32'(v[16]), 32'd0);

        // R11: stray ready while idle
        bus_read(W_STAT, st);
        spur_rdy = 1'b1; @(negedge clk); spur_rdy = 1'b0;
        bus_read(W_STAT, v); check("R11 status unchanged", v, st);

        // R9: masking and unmapped words
        rsp_delay = 0;
        bus_write(W_CTRL, 32'hFFFF_FFFF);
        bus_read(W_CTRL, v); check("R9 ctrl mask", v, 32'h307F_FFFF);
        poll_idle(st);
        check("R9 read of 0x7F", 32'(st[15:0]), 32'(pat(127)));
        bus_read(6'h05, v); check("R9 unmapped zero", v, 32'd0);
        bus_read(6'h1E, v); check("R9 unmapped zero", v, 32'd0);

        // R10: data held without a strobe
        bus_read(W_RST, v);
        repeat (3) @(negedge clk);
        check("R10 rdata held", bus_rdata, 32'h2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule